// File: doc/BRIEF.md
# Stream Event Flag Bank

This block collects completion and fault events from eight data-movement streams and holds each one as a sticky flag until software acknowledges it. Every stream has five events: FIFO fault, direct-path fault, bus fault, halfway point and done. A single-cycle pulse on an event input sets the matching flag. The flag stays set until software writes a one to the matching bit of a write-one-to-clear register.

The flags of streams 0 to 3 are packed into a low status word and those of streams 4 to 7 into a high status word. The layout is the same in both words. Each stream owns a 6-bit group whose base is decided by its slot within the word (slot 0: 0, slot 1: 6, slot 2: 16, slot 3: 22). Inside the group the FIFO fault is at +0, the direct-path fault at +2, the bus fault at +3, the halfway flag at +4 and the done flag at +5. Group bit +1 and all bits outside the groups are reserved.

Each stream drives one interrupt line. The line is high when any of its flags is set while the enable for that flag is high. The FIFO-fault enable arrives on its own input vector, separate from the four other enables.

Every flag is a two-state machine. Its states are `FL_IDLE` and `FL_PEND`. The transitions are:
- ARM: `FL_IDLE` to `FL_PEND` when an event arrives.
- ACK: `FL_PEND` to `FL_IDLE` when a clear arrives with no event in the same cycle.
- HOLD: `FL_PEND` stays in `FL_PEND` when an event arrives, with or without a clear.
- REST: `FL_IDLE` stays in `FL_IDLE` when no event arrives, whether or not a clear arrives.

Register addresses on the 2-bit port are:
- 0: low status (read-only)
- 1: high status (read-only)
- 2: low clear (write-only)
- 3: high clear (write-only)

Top module: `stream_event_flags`

## Requirements
- R1: While `rst` is high at a clock edge, all flags return to `FL_IDLE`. After that edge both status words, `rd_data` and every `irq` bit read 0.
- R2: An event pulse on stream s sets exactly one bit, in the status word for s (low for s<4, high for s>=4). The bit position is the group base for slot s mod 4 (0, 6, 16 or 22) plus the kind offset (FIFO fault +0, direct-path fault +2, bus fault +3, halfway +4, done +5). The bit is visible after the edge that samples the pulse.
- R3: Reserved bits always read 0, so each status word is masked by 0x0F7D0F7D. When every event of every stream fires, both words equal 0x0F7D0F7D.
- R4: A set flag stays set on every later cycle until a clear reaches it.
- R5: Writing to address 2 (low) or 3 (high) clears, after that edge, each flag whose bit position holds a 1 in `wr_data`. Bits written as 0 leave their flags unchanged.
- R6: When an event and a clear for the same flag fall in the same cycle, the event wins and the flag is set after that edge. This holds whether the flag was set or idle before.
- R7: Writes to addresses 0 and 1 change no flag. Reads of addresses 2 and 3 return 0.
- R8: `irq[s]` is the OR, over the five kinds, of (flag of s AND enable of that kind for s). The FIFO-fault enable comes from `en_fifo_err`; the other four come from their own vectors. The line follows enable changes in the same cycle.
- R9: `rd_data` combinationally returns `status_lo` at address 0 and `status_hi` at address 1.
- R10: A clear written to one status word's clear register never affects flags held in the other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_fifo_err | input | 8 | FIFO-fault event pulse, one bit per stream |
| ev_dm_err | input | 8 | Direct-path fault event pulse per stream |
| ev_xfer_err | input | 8 | Bus fault event pulse per stream |
| ev_half | input | 8 | Halfway event pulse per stream |
| ev_done | input | 8 | Done event pulse per stream |
| en_fifo_err | input | 8 | FIFO-fault interrupt enable per stream |
| en_dm_err | input | 8 | Direct-path fault interrupt enable per stream |
| en_xfer_err | input | 8 | Bus fault interrupt enable per stream |
| en_half | input | 8 | Halfway interrupt enable per stream |
| en_done | input | 8 | Done interrupt enable per stream |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| status_lo | output | 32 | Flags of streams 0 to 3 |
| status_hi | output | 32 | Flags of streams 4 to 7 |
| irq | output | 8 | Interrupt line per stream |

## Verification
An event pulse and a software clear can land on the same flag in the same cycle. The event must win, and this is the one ordering hazard in the bank. The bench provokes it for every stream and every kind by driving the event input and a one-bit clear write before the same rising edge. It does this once with the flag already pending and once with it idle. It then reads the status word one cycle later and expects the bit set. A follow-up clear with no event must drop the bit, which shows that the flag is not simply stuck.

// File: rtl/sef_pkg.sv
package sef_pkg;

    localparam int NSTREAM     = 8;
    localparam int NKIND       = 5;
    localparam int PER_WORD    = 4;
    localparam int NWORD       = NSTREAM / PER_WORD;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 2;
    localparam int PAIR_STRIDE = 16;
    localparam int GROUP_W     = 6;

    // Event kinds, in the order used for the per-stream flag vectors.
    typedef enum logic [2:0] {
        K_FIFO = 3'd0,
        K_DM   = 3'd1,
        K_TE   = 3'd2,
        K_HT   = 3'd3,
        K_TC   = 3'd4
    } kind_e;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_PEND = 1'b1
    } flag_state_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_STAT_LO = 2'd0,
        RA_STAT_HI = 2'd1,
        RA_CLR_LO  = 2'd2,
        RA_CLR_HI  = 2'd3
    } reg_addr_e;

    // Offset of a kind inside its stream's group; group bit 1 is reserved.
    function automatic int kind_pos(input int k);
        return (k == 0) ? 0 : k + 1;
    endfunction

    // Base bit of the group for a slot (0..3) within a status word.
    function automatic int group_base(input int slot);
        return (slot / 2) * PAIR_STRIDE + (slot % 2) * GROUP_W;
    endfunction

    function automatic logic [WORD_W-1:0] valid_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int s = 0; s < PER_WORD; s++)
            for (int k = 0; k < NKIND; k++)
                m[group_base(s) + kind_pos(k)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sef_flag_cell.sv
module sef_flag_cell
    import sef_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FL_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (set_i)            state_d = FL_PEND;  // ARM
            FL_PEND: if (clr_i && !set_i)  state_d = FL_IDLE;  // ACK, else HOLD
            default:                       state_d = FL_IDLE;
        endcase
    end

    assign pend_o = (state_q == FL_PEND);

endmodule

// File: rtl/sef_stream.sv
module sef_stream
    import sef_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NKIND-1:0] ev_i,
    input  logic [NKIND-1:0] clr_i,
    input  logic [NKIND-1:0] en_i,
    output logic [NKIND-1:0] flag_o,
    output logic             irq_o
);

    for (genvar k = 0; k < NKIND; k++) begin : g_cell
        sef_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (ev_i[k]),
            .clr_i  (clr_i[k]),
            .pend_o (flag_o[k])
        );
    end

    assign irq_o = |(flag_o & en_i);

endmodule

// File: rtl/sef_regmap.sv
module sef_regmap
    import sef_pkg::*;
(
    input  logic [NSTREAM-1:0][NKIND-1:0] flags_i,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [NSTREAM-1:0][NKIND-1:0] clr_o,
    output logic [NWORD-1:0][WORD_W-1:0]  words_o,
    output logic [WORD_W-1:0]             rd_data
);

    logic [NWORD-1:0] clr_hit;

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        localparam reg_addr_e CLR_ADDR = (w == 0) ? RA_CLR_LO : RA_CLR_HI;
        assign clr_hit[w] = wr_en && (wr_addr == CLR_ADDR);
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_map
        localparam int W    = s / PER_WORD;
        localparam int BASE = group_base(s % PER_WORD);
        for (genvar k = 0; k < NKIND; k++) begin : g_kind
            localparam int POS = BASE + kind_pos(k);
            assign clr_o[s][k] = clr_hit[W] && wr_data[POS];
        end
    end

    always_comb begin
        words_o = '0;
        for (int s = 0; s < NSTREAM; s++)
            for (int k = 0; k < NKIND; k++)
                words_o[s / PER_WORD][group_base(s % PER_WORD) + kind_pos(k)] = flags_i[s][k];
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            RA_STAT_LO: rd_data = words_o[0];
            RA_STAT_HI: rd_data = words_o[NWORD-1];
            RA_CLR_LO:  rd_data = '0;
            RA_CLR_HI:  rd_data = '0;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/stream_event_flags.sv
module stream_event_flags
    import sef_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NSTREAM-1:0] ev_fifo_err,
    input  logic [NSTREAM-1:0] ev_dm_err,
    input  logic [NSTREAM-1:0] ev_xfer_err,
    input  logic [NSTREAM-1:0] ev_half,
    input  logic [NSTREAM-1:0] ev_done,
    input  logic [NSTREAM-1:0] en_fifo_err,
    input  logic [NSTREAM-1:0] en_dm_err,
    input  logic [NSTREAM-1:0] en_xfer_err,
    input  logic [NSTREAM-1:0] en_half,
    input  logic [NSTREAM-1:0] en_done,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic [WORD_W-1:0]  status_lo,
    output logic [WORD_W-1:0]  status_hi,
    output logic [NSTREAM-1:0] irq
);

    logic [NSTREAM-1:0][NKIND-1:0] flags, clrs;
    logic [NWORD-1:0][WORD_W-1:0]  words;

    for (genvar s = 0; s < NSTREAM; s++) begin : g_strm
        logic [NKIND-1:0] ev_s, en_s;
        assign ev_s = {ev_done[s], ev_half[s], ev_xfer_err[s], ev_dm_err[s], ev_fifo_err[s]};
        // FIFO-fault enable arrives on its own path
        assign en_s = {en_done[s], en_half[s], en_xfer_err[s], en_dm_err[s], en_fifo_err[s]};

        sef_stream u_stream (
            .clk    (clk),
            .rst    (rst),
            .ev_i   (ev_s),
            .clr_i  (clrs[s]),
            .en_i   (en_s),
            .flag_o (flags[s]),
            .irq_o  (irq[s])
        );
    end

    sef_regmap u_map (
        .flags_i (flags),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .clr_o   (clrs),
        .words_o (words),
        .rd_data (rd_data)
    );

    assign status_lo = words[0];
    assign status_hi = words[NWORD-1];

endmodule

// File: rtl/sef_checker.sv
module sef_checker
    import sef_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NSTREAM-1:0] ev_fifo_err,
    input logic [NSTREAM-1:0] ev_half,
    input logic [NSTREAM-1:0] ev_done,
    input logic [NSTREAM-1:0] en_fifo_err,
    input logic [NSTREAM-1:0] en_dm_err,
    input logic [NSTREAM-1:0] en_xfer_err,
    input logic [NSTREAM-1:0] en_half,
    input logic [NSTREAM-1:0] en_done,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [WORD_W-1:0]  wr_data,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [WORD_W-1:0]  rd_data,
    input logic [WORD_W-1:0]  status_lo,
    input logic [WORD_W-1:0]  status_hi,
    input logic [NSTREAM-1:0] irq
);

    localparam logic [WORD_W-1:0] MASK = valid_mask();

    logic [WORD_W-1:0] clr_lo_w, clr_hi_w;
    assign clr_lo_w = (wr_en && wr_addr == 2'd2) ? wr_data : '0;
    assign clr_hi_w = (wr_en && wr_addr == 2'd3) ? wr_data : '0;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (status_lo == '0 && status_hi == '0 && irq == '0));

    // R2
    done_s0_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ev_done[0] |=> status_lo[5]);

    // R2
    fifo_s4_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ev_fifo_err[4] |=> status_hi[0]);

    // R2
    half_s7_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ev_half[7] |=> status_hi[26]);

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_lo | status_hi) & ~MASK) == '0);

    // R4
    sticky_lo_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_lo) & ~$past(clr_lo_w)) & ~status_lo) == '0);

    // R4
    sticky_hi_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_hi) & ~$past(clr_hi_w)) & ~status_hi) == '0);

    // R5
    clear_done_s0_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_lo_w[5] && !ev_done[0]) |=> !status_lo[5]);

    // R7
    clear_addr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_addr[1] |-> rd_data == '0);

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (irq & ~(en_fifo_err | en_dm_err | en_xfer_err | en_half | en_done)) == '0);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (status_lo == '0 && status_hi == '0) |-> irq == '0);

    // R9
    read_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 2'd0 |-> rd_data == status_lo) and (rd_addr == 2'd1 |-> rd_data == status_hi));

endmodule

bind stream_event_flags sef_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_fifo_err (ev_fifo_err),
    .ev_half     (ev_half),
    .ev_done     (ev_done),
    .en_fifo_err (en_fifo_err),
    .en_dm_err   (en_dm_err),
    .en_xfer_err (en_xfer_err),
    .en_half     (en_half),
    .en_done     (en_done),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .status_lo   (status_lo),
    .status_hi   (status_hi),
    .irq         (irq)
);

// File: tb/stream_event_flags_test.sv
`timescale 1ns/1ps
module stream_event_flags_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0][7:0] evv = '0;
    logic [4:0][7:0] env = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data, status_lo, status_hi;
    logic [7:0]  irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    stream_event_flags uut (
        .clk(clk), .rst(rst),
        .ev_fifo_err(evv[0]), .ev_dm_err(evv[1]), .ev_xfer_err(evv[2]),
        .ev_half(evv[3]), .ev_done(evv[4]),
        .en_fifo_err(env[0]), .en_dm_err(env[1]), .en_xfer_err(env[2]),
        .en_half(env[3]), .en_done(env[4]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .status_lo(status_lo), .status_hi(status_hi), .irq(irq)
    );

    localparam logic [31:0] MASK = 32'h0F7D0F7D;

    function automatic int bitpos(input int s, input int k);
        int slot;
        slot = s % 4;
        return (slot / 2) * 16 + (slot % 2) * 6 + ((k == 0) ? 0 : k + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_all();
        wreg(2'd2, 32'hFFFF_FFFF);
        wreg(2'd3, 32'hFFFF_FFFF);
    endtask

    function automatic logic [31:0] word_of(input int s);
        return (s < 4) ? status_lo : status_hi;
    endfunction

    function automatic logic [31:0] other_of(input int s);
        return (s < 4) ? status_hi : status_lo;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        logic [1:0]  ca;
        step();
        step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 lo", status_lo, 32'h0);
        chk("R1 hi", status_hi, 32'h0);
        chk("R1 irq", {24'h0, irq}, 32'h0);
        chk("R1 rd", rd_data, 32'h0);

        // Sweep every stream and kind
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 5; k++) begin
                e  = 32'h1 << bitpos(s, k);
                ca = (s < 4) ? 2'd2 : 2'd3;
                clear_all();
                evv[k][s] = 1'b1;
                step();
                evv = '0;
                chk("R2 word", word_of(s), e);
                chk("R2 other word", other_of(s), 32'h0);
                step();
                chk("R4 sticky", word_of(s), e);
                rd_addr = (s < 4) ? 2'd0 : 2'd1;
                #1 chk("R9 readback", rd_data, e);
                env[k][s] = 1'b1;
                #1 chk("R8 enabled irq", {24'h0, irq}, 32'h1 << s);
                env = ~'0;
                env[k] = '0;
                #1 chk("R8 other enables", {24'h0, irq}, 32'h0);
                env = '0;
                wreg(2'd0, 32'hFFFF_FFFF);
                wreg(2'd1, 32'hFFFF_FFFF);
                chk("R7 status write ignored", word_of(s), e);
                wreg(ca, ~e);
                chk("R5 zero bits no effect", word_of(s), e);
                wreg(ca ^ 2'd1, e);
                chk("R10 other clear no effect", word_of(s), e);
                // R6: event and clear together on a pending flag
                evv[k][s] = 1'b1;
                wreg(ca, e);
                evv = '0;
                chk("R6 collision pending", word_of(s), e);
                wreg(ca, e);
                chk("R5 clear", word_of(s), 32'h0);
                // R6: event and clear together on an idle flag
                evv[k][s] = 1'b1;
                wreg(ca, e);
                evv = '0;
                chk("R6 collision idle", word_of(s), e);
            end
        end

        // R3 all events
        clear_all();
        evv = ~'0;
        step();
        evv = '0;
        chk("R3 lo mask", status_lo, MASK);
        chk("R3 hi mask", status_hi, MASK);
        rd_addr = 2'd2;
        #1 chk("R7 read clr lo", rd_data, 32'h0);
        rd_addr = 2'd3;
        #1 chk("R7 read clr hi", rd_data, 32'h0);
        env[0] = 8'hFF;
        #1 chk("R8 fifo enable path", {24'h0, irq}, 32'hFF);
        env = '0;
        #1 chk("R8 no enables", {24'h0, irq}, 32'h0);
        // R10 clear low only
        wreg(2'd2, 32'hFFFF_FFFF);
        chk("R10 lo cleared", status_lo, 32'h0);
        chk("R10 hi kept", status_hi, MASK);
        env[4] = 8'hFF;
        #1 chk("R8 hi streams only", {24'h0, irq}, 32'hF0);
        env = '0;

        // R1 reset mid-run
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset hi", status_hi, 32'h0);
        chk("R1 reset lo", status_lo, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule